// File: doc/BRIEF.md
# Speculative Store Queue with Load Forwarding

This block holds stores that the execution pipeline has issued but the data cache has not yet absorbed. Execution goes on while the queue waits. Each store comes in with a flag that says whether it lies under an unresolved branch. Flagged entries stay in the queue and are never offered to the cache port. A misprediction pulse deletes every flagged entry at once. A correct-resolution pulse turns every flagged entry into a committed one in a single cycle.

The cache side takes committed entries through a valid/ready handshake. The queue offers the oldest committed entry whose cache line is not marked as blocked. Stores to a line that is ready can therefore leave ahead of older stores to a line that is still busy. A fence input reports busy until the queue is empty. Loads present a word address and get, in the same cycle, the data and byte enables of the youngest queued store to that word. When every slot is taken, the store-ready output drops so that the pipeline stalls.

Top module: `spec_store_buf`

## Requirements
- R1: After reset the queue is empty: st_ready is 1, and mem_valid, ld_hit and fence_busy are 0.
- R2: A store is accepted on a clock edge where st_valid and st_ready are both 1. st_ready is 0 exactly when all DEPTH slots are occupied. A store offered while st_ready is 0 is dropped: it is never forwarded and never drained.
- R3: Committed entries (st_spec = 0) appear on mem_addr/mem_data/mem_be with mem_valid = 1. An entry leaves on an edge where mem_valid and mem_ready are both 1. Among the eligible entries, the oldest is offered first.
- R4: An entry accepted with st_spec = 1 is never offered on the memory port while it is still speculative.
- R5: A resolve_bad pulse removes every speculative entry at the next edge, so later loads miss them and they are never drained. A store accepted in the same cycle as the pulse is kept.
- R6: A resolve_ok pulse clears the speculative flag of every entry at the next edge. Those entries then drain in age order.
- R7: fence_busy is 1 while fence_req is 1 and at least one entry is occupied. It is 0 otherwise.
- R8: ld_hit is 1 in the same cycle when any occupied entry has the same word address as ld_addr (address bits above the byte offset, bits AW-1:2 for 32-bit data). ld_data and ld_be then come from the youngest such entry, speculative entries included. On a miss, ld_hit, ld_data and ld_be are 0.
- R9: While blk_valid is 1, entries whose line number (address bits AW-1:5 for 32-byte lines) equals blk_line are skipped. An older entry in that line does not stop a younger entry in another line from draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request from the pipeline |
| st_ready | output | 1 | A free slot exists; store is taken this edge |
| st_addr | input | AW | Store byte address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_spec | input | 1 | Store lies under an unresolved branch |
| resolve_ok | input | 1 | Branch resolved correctly: commit all speculative entries |
| resolve_bad | input | 1 | Misprediction: discard all speculative entries |
| fence_req | input | 1 | Fence waiting for the queue to empty |
| fence_busy | output | 1 | Fence must keep stalling |
| ld_addr | input | AW | Load address to search |
| ld_hit | output | 1 | A queued store covers the load's word |
| ld_data | output | DW | Data of the youngest matching entry |
| ld_be | output | DW/8 | Byte enables of the youngest matching entry |
| blk_valid | input | 1 | Cache reports a line that cannot accept writes now |
| blk_line | input | AW-log2(LINE_BYTES) | Number of the blocked line |
| mem_valid | output | 1 | An entry is offered to the cache |
| mem_ready | input | 1 | Cache accepts the offered entry |
| mem_addr | output | AW | Offered address |
| mem_data | output | DW | Offered data |
| mem_be | output | DW/8 | Offered byte enables |

## Verification
Some properties are checked on every cycle. The slot given to a new store must be free and unique. The entry offered to the cache must be committed and outside the blocked line. After a flush or a commit pulse, no older speculative entry may remain. A finished fence must never coexist with a pending drain. Any two live entries must have a strict age order, and each picker must grant at most one slot. Other behaviour shows only in directed scenarios, checked against a scoreboard of expected cache writes. These include age-ordered draining, youngest-wins forwarding after a rewrite of the same word, a dropped store at full occupancy, a flush that coincides with a new store, and a younger line passing a blocked older one.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
   // per-slot status kept in flops; payload lives in separate arrays
   typedef struct packed {
      logic vld;
      logic spec;
   } ssb_flag_t;
endpackage

// File: rtl/ssb_match.sv
// Parallel compare of one key against a tag per slot, gated by occupancy.
module ssb_match #(
   parameter int N  = 8,
   parameter int KW = 30
) (
   input  logic [N*KW-1:0] tags,
   input  logic [KW-1:0]   key,
   input  logic [N-1:0]    en,
   output logic [N-1:0]    hit
);
   if (N < 1 || KW < 1) begin : g_bad_cfg
      $error("ssb_match: N and KW must be positive");
   end

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit[i] = en[i] && (tags[i*KW +: KW] == key);
   end
endmodule

// File: rtl/ssb_age.sv
// Age matrix: older[r*N+c] = 1 means slot r was filled before slot c.
module ssb_age #(
   parameter int N = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   alloc_oh,
   input  logic [N-1:0]   vld,
   output logic [N*N-1:0] older
);
   if (N < 2) begin : g_bad_n
      $error("ssb_age: N must be at least 2");
   end

   always_ff @(posedge clk) begin
      for (int r = 0; r < N; r++) begin
         for (int c = 0; c < N; c++) begin
            if (!rst_n)
               older[r*N+c] <= 1'b0;
            else if (alloc_oh[r])
               older[r*N+c] <= 1'b0;           // newcomer is younger than all
            else if (alloc_oh[c])
               older[r*N+c] <= vld[r];         // every live slot precedes it
         end
      end
   end

   // R3: any two live slots have exactly one order between them
   for (genvar a = 0; a < N; a++) begin : g_pair_a
      for (genvar b = a + 1; b < N; b++) begin : g_pair_b
         // R3
         age_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vld[a] && vld[b]) |-> (older[a*N+b] != older[b*N+a]));
      end
   end
endmodule

// File: rtl/ssb_pick.sv
// Chooses one candidate slot by age; YOUNGEST selects the variant.
module ssb_pick #(
   parameter int N        = 8,
   parameter bit YOUNGEST = 1'b0,
   localparam int IW      = (N > 1) ? $clog2(N) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   cand,
   input  logic [N*N-1:0] older,
   output logic [N-1:0]   grant,
   output logic           any,
   output logic [IW-1:0]  idx
);
   if (YOUNGEST) begin : g_young
      // winner has no younger competitor
      always_comb begin
         for (int i = 0; i < N; i++) begin
            grant[i] = cand[i] && ((cand & older[i*N +: N]) == '0);
         end
      end
   end else begin : g_old
      // winner has no older competitor
      always_comb begin
         for (int i = 0; i < N; i++) begin
            logic blk;
            blk = 1'b0;
            for (int j = 0; j < N; j++) begin
               blk = blk | (cand[j] & older[j*N+i]);
            end
            grant[i] = cand[i] && !blk;
         end
      end
   end

   assign any = |cand;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = idx | IW'(i);
      end
   end

   // R3 R8: a non-empty candidate set yields exactly one winner
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> $onehot(grant));
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
   import ssb_pkg::*;
#(
   parameter int DEPTH      = 8,
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int LINE_BYTES = 32,
   localparam int BEW  = DW / 8,
   localparam int IDXW = $clog2(DEPTH),
   localparam int WOFF = $clog2(BEW),
   localparam int LOFF = $clog2(LINE_BYTES),
   localparam int WKW  = AW - WOFF,
   localparam int LW   = AW - LOFF
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           st_valid,
   output logic           st_ready,
   input  logic [AW-1:0]  st_addr,
   input  logic [DW-1:0]  st_data,
   input  logic [BEW-1:0] st_be,
   input  logic           st_spec,
   input  logic           resolve_ok,
   input  logic           resolve_bad,
   input  logic           fence_req,
   output logic           fence_busy,
   input  logic [AW-1:0]  ld_addr,
   output logic           ld_hit,
   output logic [DW-1:0]  ld_data,
   output logic [BEW-1:0] ld_be,
   input  logic           blk_valid,
   input  logic [LW-1:0]  blk_line,
   output logic           mem_valid,
   input  logic           mem_ready,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_data,
   output logic [BEW-1:0] mem_be
);
   // ---------------- elaboration checks ----------------
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spec_store_buf: DEPTH must be a power of two >= 2");
   end
   if (DW < 8 || (DW % 8) != 0 || (BEW & (BEW - 1)) != 0) begin : g_bad_dw
      $error("spec_store_buf: DW must be 8 times a power of two");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < BEW || LOFF >= AW) begin : g_bad_line
      $error("spec_store_buf: LINE_BYTES must be a power of two not below the word size");
   end

   // ---------------- storage ----------------
   ssb_flag_t      flg    [DEPTH];
   logic [AW-1:0]  addr_q [DEPTH];
   logic [DW-1:0]  data_q [DEPTH];
   logic [BEW-1:0] be_q   [DEPTH];

   logic [DEPTH-1:0]       vld_vec, spec_vec;
   logic [DEPTH-1:0]       free_oh, push_oh, new_spec_oh;
   logic [DEPTH-1:0]       line_hit, word_hit, drn_cand;
   logic [DEPTH-1:0]       drn_oh, fwd_oh;
   logic [DEPTH*DEPTH-1:0] older;
   logic [DEPTH*WKW-1:0]   word_tags;
   logic [DEPTH*LW-1:0]    line_tags;
   logic [IDXW-1:0]        drn_idx, fwd_idx;
   logic                   drn_any, fwd_any, st_push, drn_fire;
   logic                   unused_ld_lsb;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         vld_vec[i]  = flg[i].vld;
         spec_vec[i] = flg[i].spec;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_tags
      assign word_tags[i*WKW +: WKW] = addr_q[i][AW-1:WOFF];
      assign line_tags[i*LW +: LW]   = addr_q[i][AW-1:LOFF];
   end

   // ---------------- allocation ----------------
   always_comb begin
      logic found;
      found   = 1'b0;
      free_oh = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!vld_vec[i] && !found) begin
            free_oh[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   assign st_ready    = ~&vld_vec;
   assign st_push     = st_valid && st_ready;
   assign push_oh     = free_oh & {DEPTH{st_push}};
   assign new_spec_oh = push_oh & {DEPTH{st_spec}};

   ssb_age #(.N(DEPTH)) u_age (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_oh (push_oh),
      .vld      (vld_vec),
      .older    (older)
   );

   // ---------------- drain side ----------------
   ssb_match #(.N(DEPTH), .KW(LW)) u_line_cmp (
      .tags (line_tags),
      .key  (blk_line),
      .en   (vld_vec),
      .hit  (line_hit)
   );

   assign drn_cand = vld_vec & ~spec_vec & ~(line_hit & {DEPTH{blk_valid}});

   ssb_pick #(.N(DEPTH), .YOUNGEST(1'b0)) u_drain_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .cand  (drn_cand),
      .older (older),
      .grant (drn_oh),
      .any   (drn_any),
      .idx   (drn_idx)
   );

   assign mem_valid = drn_any;
   assign mem_addr  = addr_q[drn_idx];
   assign mem_data  = data_q[drn_idx];
   assign mem_be    = be_q[drn_idx];
   assign drn_fire  = mem_valid && mem_ready;

   // ---------------- load forwarding ----------------
   ssb_match #(.N(DEPTH), .KW(WKW)) u_word_cmp (
      .tags (word_tags),
      .key  (ld_addr[AW-1:WOFF]),
      .en   (vld_vec),
      .hit  (word_hit)
   );

   ssb_pick #(.N(DEPTH), .YOUNGEST(1'b1)) u_fwd_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .cand  (word_hit),
      .older (older),
      .grant (fwd_oh),
      .any   (fwd_any),
      .idx   (fwd_idx)
   );

   assign unused_ld_lsb = ^ld_addr[WOFF-1:0];
   assign ld_hit  = fwd_any;
   assign ld_data = fwd_any ? data_q[fwd_idx] : '0;
   assign ld_be   = fwd_any ? be_q[fwd_idx]   : '0;

   assign fence_busy = fence_req && (|vld_vec);

   // ---------------- state update ----------------
   // A misprediction overrides a simultaneous commit pulse: dropped entries stay dropped.
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (!rst_n) begin
            flg[i] <= '0;
         end else begin
            if (drn_fire && drn_oh[i])        flg[i].vld  <= 1'b0;
            if (resolve_bad && flg[i].spec)   flg[i].vld  <= 1'b0;
            if (resolve_ok)                   flg[i].spec <= 1'b0;
            if (push_oh[i]) begin
               flg[i].vld  <= 1'b1;
               flg[i].spec <= st_spec;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push_oh[i]) begin
            addr_q[i] <= st_addr;
            data_q[i] <= st_data;
            be_q[i]   <= st_be;
         end
      end
   end

   // ---------------- assertions ----------------
   // R2
   alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_push |-> ($onehot(free_oh) && ((free_oh & vld_vec) == '0)));

   // R4
   drain_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (((drn_oh & spec_vec) == '0) && ((drn_oh & vld_vec) != '0)));

   // R5
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resolve_bad |=> ((vld_vec & spec_vec & ~$past(new_spec_oh)) == '0));

   // R6
   promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resolve_ok |=> ((vld_vec & spec_vec & ~$past(new_spec_oh)) == '0));

   // R7
   fence_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fence_req && !fence_busy) |-> !mem_valid);

   // R9
   blk_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && blk_valid) |-> (mem_addr[AW-1:LOFF] != blk_line));
endmodule

// File: tb/spec_store_buf_tb.sv
module spec_store_buf_tb;
   localparam int AW  = 32;
   localparam int DW  = 32;
   localparam int BEW = 4;
   localparam int LW  = 27;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           st_valid, st_ready, st_spec;
   logic [AW-1:0]  st_addr;
   logic [DW-1:0]  st_data;
   logic [BEW-1:0] st_be;
   logic           resolve_ok, resolve_bad, fence_req, fence_busy;
   logic [AW-1:0]  ld_addr;
   logic           ld_hit;
   logic [DW-1:0]  ld_data;
   logic [BEW-1:0] ld_be;
   logic           blk_valid;
   logic [LW-1:0]  blk_line;
   logic           mem_valid, mem_ready;
   logic [AW-1:0]  mem_addr;
   logic [DW-1:0]  mem_data;
   logic [BEW-1:0] mem_be;

   int    ncmp = 0;
   int    nerr = 0;
   string mon_req = "R3";
   logic [AW+DW+BEW-1:0] exp_q[$];

   always #2.5 clk = ~clk;   // 200 MHz

   spec_store_buf u_dut (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
      .st_data(st_data), .st_be(st_be), .st_spec(st_spec),
      .resolve_ok(resolve_ok), .resolve_bad(resolve_bad),
      .fence_req(fence_req), .fence_busy(fence_busy),
      .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data), .ld_be(ld_be),
      .blk_valid(blk_valid), .blk_line(blk_line),
      .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      ncmp++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [BEW-1:0] b, input logic s);
      @(negedge clk);
      st_valid = 1'b1; st_addr = a; st_data = d; st_be = b; st_spec = s;
      @(posedge clk); #1;
      st_valid = 1'b0;
   endtask

   task automatic expect_drain(input logic [AW-1:0] a, input logic [DW-1:0] d,
                               input logic [BEW-1:0] b);
      exp_q.push_back({a, d, b});
   endtask

   task automatic check_ld(input string req, input logic [AW-1:0] a, input logic h,
                           input logic [DW-1:0] d, input logic [BEW-1:0] b);
      @(negedge clk);
      ld_addr = a;
      #1;
      chk(req, 128'(ld_hit), 128'(h));
      chk(req, 128'({ld_data, ld_be}), 128'({d, b}));
   endtask

   // scoreboard monitor: every cache handshake must match the next expected write
   always begin
      @(negedge clk); #1;
      if (rst_n === 1'b1 && mem_valid && mem_ready) begin
         if (exp_q.size() == 0) begin
            ncmp++; nerr++;
            $display("FAIL %s: actual=%0h expected=none (unexpected drain)",
                     mon_req, {mem_addr, mem_data, mem_be});
         end else begin
            chk(mon_req, 128'({mem_addr, mem_data, mem_be}), 128'(exp_q.pop_front()));
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      ncmp++; nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
   end

   initial begin
      rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0;
      st_spec = 1'b0; resolve_ok = 1'b0; resolve_bad = 1'b0; fence_req = 1'b0;
      ld_addr = '0; blk_valid = 1'b0; blk_line = '0; mem_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", 128'(st_ready), 128'(1));
      chk("R1", 128'(mem_valid), 128'(0));
      chk("R1", 128'(ld_hit), 128'(0));
      chk("R1", 128'(fence_busy), 128'(0));

      // ---- ordering, forwarding and fence ----
      push(32'h100, 32'h1111_1111, 4'hF, 1'b0);
      push(32'h140, 32'h2222_2222, 4'hF, 1'b0);
      push(32'h100, 32'hAABB_CCDD, 4'h3, 1'b0);
      expect_drain(32'h100, 32'h1111_1111, 4'hF);
      expect_drain(32'h140, 32'h2222_2222, 4'hF);
      expect_drain(32'h100, 32'hAABB_CCDD, 4'h3);
      check_ld("R8", 32'h103, 1'b1, 32'hAABB_CCDD, 4'h3);   // youngest wins
      check_ld("R8", 32'h140, 1'b1, 32'h2222_2222, 4'hF);
      check_ld("R8", 32'h180, 1'b0, 32'h0, 4'h0);
      @(negedge clk);
      fence_req = 1'b1; mem_ready = 1'b1;
      #1;
      chk("R7", 128'(fence_busy), 128'(1));
      repeat (4) @(negedge clk);
      #1;
      chk("R7", 128'(fence_busy), 128'(0));
      chk("R3", 128'(mem_valid), 128'(0));
      chk("R3", 128'(exp_q.size()), 128'(0));
      fence_req = 1'b0; mem_ready = 1'b0;

      // ---- full queue back-pressure ----
      mon_req = "R2";
      for (int k = 0; k < 8; k++) begin
         push(32'h1000 + 32'(k) * 32'h40, 32'hD000_0000 + 32'(k), 4'hF, 1'b0);
         expect_drain(32'h1000 + 32'(k) * 32'h40, 32'hD000_0000 + 32'(k), 4'hF);
      end
      @(negedge clk); #1;
      chk("R2", 128'(st_ready), 128'(0));
      push(32'h2000, 32'h9999_9999, 4'hF, 1'b0);      // offered while full
      check_ld("R2", 32'h2000, 1'b0, 32'h0, 4'h0);
      @(negedge clk);
      mem_ready = 1'b1;
      repeat (10) @(negedge clk);
      #1;
      chk("R2", 128'(exp_q.size()), 128'(0));
      chk("R2", 128'(mem_valid), 128'(0));
      chk("R2", 128'(st_ready), 128'(1));
      mem_ready = 1'b0;
      check_ld("R2", 32'h2000, 1'b0, 32'h0, 4'h0);

      // ---- speculation: hold, flush, promote ----
      mon_req = "R4";
      push(32'h300, 32'h0000_0033, 4'hF, 1'b0);
      push(32'h340, 32'h0000_0044, 4'hF, 1'b1);
      push(32'h380, 32'h0000_0055, 4'hF, 1'b1);
      check_ld("R8", 32'h340, 1'b1, 32'h0000_0044, 4'hF);
      expect_drain(32'h300, 32'h0000_0033, 4'hF);
      @(negedge clk);
      mem_ready = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk("R4", 128'(exp_q.size()), 128'(0));
      chk("R4", 128'(mem_valid), 128'(0));
      check_ld("R4", 32'h380, 1'b1, 32'h0000_0055, 4'hF);
      mon_req = "R5";
      @(negedge clk);
      resolve_bad = 1'b1;
      st_valid = 1'b1; st_addr = 32'h3C0; st_data = 32'h0000_0066; st_be = 4'hF; st_spec = 1'b1;
      @(posedge clk); #1;
      resolve_bad = 1'b0; st_valid = 1'b0;
      check_ld("R5", 32'h340, 1'b0, 32'h0, 4'h0);
      check_ld("R5", 32'h380, 1'b0, 32'h0, 4'h0);
      check_ld("R5", 32'h3C0, 1'b1, 32'h0000_0066, 4'hF);
      repeat (2) @(negedge clk);
      #1;
      chk("R4", 128'(mem_valid), 128'(0));
      mon_req = "R6";
      expect_drain(32'h3C0, 32'h0000_0066, 4'hF);
      @(negedge clk);
      resolve_ok = 1'b1;
      @(posedge clk); #1;
      resolve_ok = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R6", 128'(exp_q.size()), 128'(0));
      chk("R6", 128'(mem_valid), 128'(0));
      mem_ready = 1'b0;

      // ---- blocked line lets a younger line pass ----
      mon_req = "R9";
      push(32'h500, 32'h0000_00A1, 4'hF, 1'b0);
      push(32'h504, 32'h0000_00A2, 4'hF, 1'b0);
      push(32'h600, 32'h0000_00A3, 4'hF, 1'b0);
      expect_drain(32'h600, 32'h0000_00A3, 4'hF);
      @(negedge clk);
      blk_valid = 1'b1; blk_line = LW'(32'h500 >> 5); mem_ready = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk("R9", 128'(exp_q.size()), 128'(0));
      chk("R9", 128'(mem_valid), 128'(0));
      expect_drain(32'h500, 32'h0000_00A1, 4'hF);
      expect_drain(32'h504, 32'h0000_00A2, 4'hF);
      @(negedge clk);
      blk_valid = 1'b0;
      repeat (4) @(negedge clk);
      #1;
      chk("R9", 128'(exp_q.size()), 128'(0));
      chk("R9", 128'(mem_valid), 128'(0));
      mem_ready = 1'b0;

      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
   end
endmodule